// File: doc/BRIEF.md
# DRAM ODT Timing Generator

This block drives the on-die termination (ODT) output of a DRAM controller. The command scheduler sends it single-cycle read and write strobes. For each command the block waits a programmed number of memory clock cycles and then raises ODT. It keeps ODT high for a programmed number of cycles and then drops it. Reads and writes each have their own delay and their own high-time. All four values are 6-bit fields in one 32-bit read/write configuration register.

The block keeps up to two scheduled windows in flight at once. ODT is the OR of every window that is pending or active, so overlapping commands extend the termination to the later fall time. The timing of a window is fixed when its command is accepted. If a command needs a window slot and none is free, the command is dropped and a sticky overflow flag is raised.

Top module: `odt_timing_gen`

## Requirements
- R1: After reset the configuration register reads 0, `odt` is low and `ovf_sticky` is low.
- R2: The register holds the write delay in bits 5:0, the read delay in bits 11:6, the write high-time in bits 17:12 and the read high-time in bits 23:18. All 32 bits, including the spare bits 31:24, are stored on a write and returned on `cfg_rdata` from the next cycle.
- R3: A write strobe seen in cycle c with write delay D and write high-time P (P > 0) makes `odt` high in cycles c+D through c+D+P-1.
- R4: A read strobe behaves in the same way, using the read delay and read high-time fields.
- R5: A delay of 0 raises `odt` combinationally in the same cycle as the strobe.
- R6: A high-time of 0 produces no pulse and occupies no window slot.
- R7: When windows overlap or follow each other, `odt` is the OR of all accepted windows.
- R8: Timing values are captured when the strobe is seen. A register write in the same cycle or any later cycle does not change a window already scheduled.
- R9: If both strobes are high in one cycle, the write timing is used and the read strobe is ignored.
- R10: At most two windows are held. A window occupies a slot from the cycle after its strobe through its last high cycle, except a delay-0, high-time-1 window, which needs no slot. A strobe that needs a slot when both are occupied is dropped and has no effect on `odt`.
- R11: A dropped strobe sets `ovf_sticky`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration register contents |
| cmd_wr | input | 1 | Write command strobe, one cycle |
| cmd_rd | input | 1 | Read command strobe, one cycle |
| odt | output | 1 | On-die termination enable |
| ovf_sticky | output | 1 | Set when a command is dropped for lack of a slot |

## Verification
The assertions assume that each strobe is a single-cycle pulse and that `cfg_wdata` is stable while `cfg_we` is high. The same-cycle ODT property also assumes that the register value visible on `cfg_rdata` is the one used by the strobe in that cycle. The bench drives every input at the falling clock edge from one task at a time, so none of these assumptions is broken. It asserts both strobes together only in the priority scenario, and the dual-strobe cases are written so that those properties still hold there.

// File: rtl/odt_pkg.sv
package odt_pkg;
   localparam int ODT_FIELD_W_DEF = 6;
   localparam int ODT_REG_W_DEF   = 32;
   localparam int ODT_SLOTS_DEF   = 2;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2
   } cmd_kind_e;
endpackage

// File: rtl/odt_cfg_reg.sv
module odt_cfg_reg
   import odt_pkg::*;
#(
   parameter int REG_W = ODT_REG_W_DEF,
   parameter int TW    = ODT_FIELD_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [TW-1:0]    wr_dly,
   output logic [TW-1:0]    rd_dly,
   output logic [TW-1:0]    wr_len,
   output logic [TW-1:0]    rd_len
);
   localparam int WR_DLY_LSB = 0;
   localparam int RD_DLY_LSB = TW;
   localparam int WR_LEN_LSB = 2 * TW;
   localparam int RD_LEN_LSB = 3 * TW;

   logic [REG_W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else if (we) begin
         store_q <= wdata;
      end
   end

   assign rdata  = store_q;
   assign wr_dly = store_q[WR_DLY_LSB +: TW];
   assign rd_dly = store_q[RD_DLY_LSB +: TW];
   assign wr_len = store_q[WR_LEN_LSB +: TW];
   assign rd_len = store_q[RD_LEN_LSB +: TW];
endmodule

// File: rtl/odt_cmd_sel.sv
module odt_cmd_sel
   import odt_pkg::*;
#(
   parameter int TW       = ODT_FIELD_W_DEF,
   parameter bit WR_FIRST = 1'b1
) (
   input  logic          cmd_wr,
   input  logic          cmd_rd,
   input  logic [TW-1:0] wr_dly,
   input  logic [TW-1:0] rd_dly,
   input  logic [TW-1:0] wr_len,
   input  logic [TW-1:0] rd_len,
   output logic          fire,
   output logic          imm,
   output logic          need_slot,
   output logic [TW-1:0] slot_dly,
   output logic [TW-1:0] slot_len
);
   localparam logic [TW-1:0] ONE = TW'(1);

   cmd_kind_e     kind;
   logic [TW-1:0] sel_dly;
   logic [TW-1:0] sel_len;

   generate
      if (WR_FIRST) begin : g_wr_first
         always_comb begin
            if (cmd_wr)      kind = CMD_WRITE;
            else if (cmd_rd) kind = CMD_READ;
            else             kind = CMD_NONE;
         end
      end else begin : g_rd_first
         always_comb begin
            if (cmd_rd)      kind = CMD_READ;
            else if (cmd_wr) kind = CMD_WRITE;
            else             kind = CMD_NONE;
         end
      end
   endgenerate

   always_comb begin
      unique case (kind)
         CMD_WRITE: begin
            sel_dly = wr_dly;
            sel_len = wr_len;
         end
         CMD_READ: begin
            sel_dly = rd_dly;
            sel_len = rd_len;
         end
         default: begin
            sel_dly = '0;
            sel_len = '0;
         end
      endcase
   end

   always_comb begin
      fire      = (kind != CMD_NONE) && (sel_len != '0);
      imm       = fire && (sel_dly == '0);
      need_slot = fire && !((sel_dly == '0) && (sel_len == ONE));
      if (sel_dly == '0) begin
         slot_dly = '0;
         slot_len = sel_len - ONE;
      end else begin
         slot_dly = sel_dly - ONE;
         slot_len = sel_len;
      end
   end
endmodule

// File: rtl/odt_window_slot.sv
module odt_window_slot
   import odt_pkg::*;
#(
   parameter int TW = ODT_FIELD_W_DEF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] dly_in,
   input  logic [TW-1:0] len_in,
   output logic          busy,
   output logic          high
);
   localparam logic [TW-1:0] ONE = TW'(1);

   logic          busy_q;
   logic [TW-1:0] dly_q;
   logic [TW-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dly_q  <= '0;
         len_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         dly_q  <= dly_in;
         len_q  <= len_in;
      end else if (busy_q) begin
         if (dly_q != '0) begin
            dly_q <= dly_q - ONE;
         end else if (len_q <= ONE) begin
            busy_q <= 1'b0;
            len_q  <= '0;
         end else begin
            len_q <= len_q - ONE;
         end
      end
   end

   assign busy = busy_q;
   assign high = busy_q && (dly_q == '0);
endmodule

// File: rtl/odt_timing_gen.sv
module odt_timing_gen
   import odt_pkg::*;
#(
   parameter int REG_W    = ODT_REG_W_DEF,
   parameter int TW       = ODT_FIELD_W_DEF,
   parameter int SLOTS    = ODT_SLOTS_DEF,
   parameter bit WR_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             cmd_wr,
   input  logic             cmd_rd,
   output logic             odt,
   output logic             ovf_sticky
);
   localparam int FIELDS_W = 4 * TW;

   generate
      if (FIELDS_W > REG_W) begin : g_bad_width
         $error("odt_timing_gen: four timing fields do not fit in the register");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("odt_timing_gen: at least one window slot is required");
      end
   endgenerate

   logic [TW-1:0]    wr_dly, rd_dly, wr_len, rd_len;
   logic             fire, imm, need_slot;
   logic [TW-1:0]    slot_dly, slot_len;
   logic [SLOTS-1:0] slot_busy;
   logic [SLOTS-1:0] slot_high;
   logic [SLOTS-1:0] slot_load;
   logic             any_free;
   logic             drop;
   logic             ovf_q;

   odt_cfg_reg #(.REG_W(REG_W), .TW(TW)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .wr_dly (wr_dly),
      .rd_dly (rd_dly),
      .wr_len (wr_len),
      .rd_len (rd_len)
   );

   odt_cmd_sel #(.TW(TW), .WR_FIRST(WR_FIRST)) u_sel (
      .cmd_wr    (cmd_wr),
      .cmd_rd    (cmd_rd),
      .wr_dly    (wr_dly),
      .rd_dly    (rd_dly),
      .wr_len    (wr_len),
      .rd_len    (rd_len),
      .fire      (fire),
      .imm       (imm),
      .need_slot (need_slot),
      .slot_dly  (slot_dly),
      .slot_len  (slot_len)
   );

   assign any_free = ~&slot_busy;
   assign drop     = need_slot && !any_free;

   always_comb begin
      logic taken;
      taken     = 1'b0;
      slot_load = '0;
      for (int k = 0; k < SLOTS; k++) begin
         if (!taken && !slot_busy[k]) begin
            slot_load[k] = need_slot;
            taken        = 1'b1;
         end
      end
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         odt_window_slot #(.TW(TW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (slot_load[s]),
            .dly_in (slot_dly),
            .len_in (slot_len),
            .busy   (slot_busy[s]),
            .high   (slot_high[s])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (drop) begin
         ovf_q <= 1'b1;
      end
   end

   assign odt        = (|slot_high) || (imm && !drop);
   assign ovf_sticky = ovf_q;
endmodule

// File: rtl/odt_timing_chk.sv
module odt_timing_chk #(
   parameter int REG_W = 32,
   parameter int TW    = 6,
   parameter int SLOTS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [REG_W-1:0] cfg_wdata,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             cmd_wr,
   input logic             cmd_rd,
   input logic             odt,
   input logic             ovf_sticky,
   input logic [SLOTS-1:0] slot_busy
);
   // R2
   reg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

   // R2
   reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_sticky |=> ovf_sticky);

   // R11
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_sticky) |-> $past(cmd_wr || cmd_rd));

   // R7
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_busy == '0) && !cmd_wr && !cmd_rd) |-> !odt);

   // R5
   imm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (cfg_rdata[TW-1:0] == '0) && (cfg_rdata[3*TW-1:2*TW] != '0)
       && !(&slot_busy)) |-> odt);
endmodule

bind odt_timing_gen odt_timing_chk #(.REG_W(REG_W), .TW(TW), .SLOTS(SLOTS)) u_odt_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .cmd_wr     (cmd_wr),
   .cmd_rd     (cmd_rd),
   .odt        (odt),
   .ovf_sticky (ovf_sticky),
   .slot_busy  (slot_busy)
);

// File: tb/test_odt_timing_gen.sv
`timescale 1ns/1ps
module test_odt_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cmd_wr = 1'b0;
   logic        cmd_rd = 1'b0;
   logic        odt;
   logic        ovf_sticky;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   odt_timing_gen i_odt_timing_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .cmd_wr     (cmd_wr),
      .cmd_rd     (cmd_rd),
      .odt        (odt),
      .ovf_sticky (ovf_sticky)
   );

   function automatic logic [31:0] mk(input int wdly, input int rdly, input int wlen,
                                      input int rlen, input logic [7:0] spare);
      logic [31:0] v;
      v = {spare, 24'h0};
      v[5:0]   = 6'(wdly);
      v[11:6]  = 6'(rdly);
      v[17:12] = 6'(wlen);
      v[23:18] = 6'(rlen);
      return v;
   endfunction

   // Expected ODT trace built from the requirements: {dropped, trace}
   function automatic logic [128:0] model(input logic [127:0] wp, input logic [127:0] rp,
                                          input logic [31:0] cfg);
      logic [127:0] exp_v;
      logic         dropped;
      int           last_busy [2];
      exp_v = '0;
      dropped = 1'b0;
      last_busy[0] = -1;
      last_busy[1] = -1;
      for (int j = 0; j < 128; j++) begin
         if (wp[j] || rp[j]) begin
            int dly, len, cnt;
            bit need;
            dly = wp[j] ? int'(cfg[5:0])   : int'(cfg[11:6]);
            len = wp[j] ? int'(cfg[17:12]) : int'(cfg[23:18]);
            if (len != 0) begin
               need = (dly + len) > 1;
               cnt = 0;
               for (int k = 0; k < 2; k++) if (last_busy[k] >= j) cnt++;
               if (need && cnt >= 2) begin
                  dropped = 1'b1;
               end else begin
                  for (int t = j + dly; t < j + dly + len; t++) if (t < 128) exp_v[t] = 1'b1;
                  if (need) begin
                     if (last_busy[0] < j) last_busy[0] = j + dly + len - 1;
                     else                  last_busy[1] = j + dly + len - 1;
                  end
               end
            end
         end
      end
      return {dropped, exp_v};
   endfunction

   task automatic chk_vec(input string tag, input logic [127:0] got, input logic [127:0] exp_v);
      n_run++;
      if (got !== exp_v) begin
         n_fail++;
         $display("FAIL %s odt trace got=%h exp=%h", tag, got, exp_v);
      end
   endtask

   task automatic chk_val(input string tag, input logic [31:0] got, input logic [31:0] exp_v);
      n_run++;
      if (got !== exp_v) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp_v);
      end
   endtask

   task automatic write_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic play(input logic [127:0] wp, input logic [127:0] rp, input int we_cyc,
                       input logic [31:0] we_val, output logic [127:0] got);
      got = '0;
      for (int i = 0; i < 128; i++) begin
         @(negedge clk);
         cmd_wr = wp[i];
         cmd_rd = rp[i];
         cfg_we = (i == we_cyc);
         cfg_wdata = we_val;
         #1 got[i] = odt;
      end
      @(negedge clk);
      cmd_wr = 1'b0;
      cmd_rd = 1'b0;
      cfg_we = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic run_case(input string tag, input logic [31:0] cfg, input logic [127:0] wp,
                           input logic [127:0] rp);
      logic [127:0] got;
      logic [128:0] m;
      write_cfg(cfg);
      m = model(wp, rp, cfg);
      play(wp, rp, -1, '0, got);
      chk_vec(tag, got, m[127:0]);
   endtask

   task automatic t_reset();
      #1;
      chk_val("R1 cfg_rdata after reset", cfg_rdata, 32'h0);
      chk_val("R1 odt after reset", {31'h0, odt}, 32'h0);
      chk_val("R1 ovf after reset", {31'h0, ovf_sticky}, 32'h0);
   endtask

   task automatic t_register();
      write_cfg(32'hA5C3_5A96);
      #1 chk_val("R2 full word readback incl spare bits", cfg_rdata, 32'hA5C3_5A96);
      write_cfg(32'h5A00_0000);
      #1 chk_val("R2 spare bits alone", cfg_rdata, 32'h5A00_0000);
   endtask

   task automatic t_write_cmd();
      logic [127:0] wp = '0;
      wp[0] = 1'b1;
      run_case("R3 write delay 3 len 4", mk(3, 9, 4, 7, 8'h00), wp, '0);
      run_case("R3 write delay 63 len 1", mk(63, 1, 1, 1, 8'h00), wp, '0);
   endtask

   task automatic t_read_cmd();
      logic [127:0] rp = '0;
      rp[0] = 1'b1;
      run_case("R4 read delay 5 len 2", mk(2, 5, 9, 2, 8'hFF), '0, rp);
      run_case("R4 read delay 1 len 63", mk(7, 1, 3, 63, 8'h00), '0, rp);
   endtask

   task automatic t_zero_delay();
      logic [127:0] wp = '0;
      logic [127:0] rp = '0;
      wp[0] = 1'b1;
      rp[20] = 1'b1;
      run_case("R5 delay 0 rises same cycle", mk(0, 0, 3, 1, 8'h00), wp, rp);
   endtask

   task automatic t_zero_len();
      logic [127:0] wp = '0;
      logic [127:0] rp = '0;
      wp[0] = 1'b1;
      rp[3] = 1'b1;
      wp[6] = 1'b1;
      rp[8] = 1'b1;
      wp[9] = 1'b1;
      // zero-length write strobes take no slot, so the reads are both kept
      run_case("R6 zero length gives no pulse", mk(2, 4, 0, 3, 8'h00), wp, rp);
   endtask

   task automatic t_overlap();
      logic [127:0] wp = '0;
      logic [127:0] rp = '0;
      wp[0] = 1'b1;
      rp[3] = 1'b1;
      wp[40] = 1'b1;
      wp[50] = 1'b1;
      run_case("R7 overlapping and separate windows", mk(2, 1, 3, 8, 8'h00), wp, rp);
   endtask

   task automatic t_priority();
      logic [127:0] both = '0;
      both[0] = 1'b1;
      both[30] = 1'b1;
      run_case("R9 both strobes use write timing", mk(2, 6, 3, 10, 8'h00), both, both);
   endtask

   task automatic t_sampling();
      logic [127:0] wp = '0;
      logic [127:0] got;
      logic [128:0] m;
      logic [31:0]  cfg_a;
      wp[0] = 1'b1;
      cfg_a = mk(4, 4, 6, 6, 8'h00);
      write_cfg(cfg_a);
      m = model(wp, '0, cfg_a);
      play(wp, '0, 2, mk(1, 1, 1, 1, 8'h00), got);
      chk_vec("R8 write during delay keeps window", got, m[127:0]);
      write_cfg(cfg_a);
      play(wp, '0, 0, mk(9, 9, 20, 20, 8'h00), got);
      chk_vec("R8 write in strobe cycle keeps window", got, m[127:0]);
   endtask

   task automatic t_overflow();
      logic [127:0] wp = '0;
      logic [127:0] got;
      logic [128:0] m;
      logic [31:0]  cfg_a;
      wp[0] = 1'b1;
      wp[1] = 1'b1;
      wp[2] = 1'b1;
      wp[30] = 1'b1;
      cfg_a = mk(2, 2, 20, 20, 8'h00);
      write_cfg(cfg_a);
      #1 chk_val("R11 ovf low before drop", {31'h0, ovf_sticky}, 32'h0);
      m = model(wp, '0, cfg_a);
      play(wp, '0, -1, '0, got);
      chk_vec("R10 third strobe dropped, later one kept", got, m[127:0]);
      chk_val("R10 model saw a drop", {31'h0, m[128]}, 32'h1);
      chk_val("R11 ovf set by drop", {31'h0, ovf_sticky}, 32'h1);
      repeat (20) @(negedge clk);
      #1 chk_val("R11 ovf stays set", {31'h0, ovf_sticky}, 32'h1);
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_register();
      t_write_cmd();
      t_read_cmd();
      t_zero_delay();
      t_zero_len();
      t_overlap();
      t_priority();
      t_sampling();
      t_overflow();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule